// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block collects the event sources of a serial port into one status word and drives a single interrupt request from it. There are six sources. Transmit request, framing error, break and receive overrun arrive as one-cycle pulses and are held in sticky bits. Software clears each sticky bit by writing a one to it. The receive-trigger and receive-timeout conditions are levels that the receive FIFO drives, and the status word shows them as they are.

A software set strobe can raise a force-transmit bit, which requests a transmit interrupt with no FIFO activity. The bits fall into three groups: transmit (TX request, force), receive (trigger, timeout) and error (framing, break, overrun). Each group has its own enable. The interrupt line is active while any enabled group has a set bit. The enables gate only the interrupt line, so a source still records its bit while its group is disabled. Before software refills the transmit FIFO, it clears the TX request bit with a one-to-clear write.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and once it is released, status_o reads 0 and irq_o reads 0 until an event arrives.
- R2: A pulse on tx_req_evt_i, frame_err_evt_i, brk_evt_i or ovr_evt_i sets status bit 0, 3, 4 or 5 in turn at the next rising clock edge. The bit stays set after the pulse ends.
- R3: When clr_we_i is high, each status bit 0, 3, 4, 5 or 6 whose wr_data_i bit is 1 is cleared at the next edge. Bits written with 0 keep their value.
- R4: If an event pulse and a clearing write meet the same sticky bit in the same cycle, the bit stays set.
- R5: Status bit 1 equals rx_trig_lvl_i and bit 2 equals rx_tmo_lvl_i at all times. A clearing write has no effect on them.
- R6: When set_we_i is high and wr_data_i bit 6 is 1, the force-transmit bit (status bit 6) is set at the next edge. No other bit can be set by a set write. If a set and a clear of bit 6 occur in the same cycle, the bit stays set.
- R7: irq_o = (tx_ie_i & (bit0 | bit6)) | (rx_ie_i & (bit1 | bit2)) | (err_ie_i & (bit3 | bit4 | bit5)).
- R8: The enable inputs have no effect on whether status bits are set or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_req_evt_i | input | 1 | Transmit request pulse |
| rx_trig_lvl_i | input | 1 | Receive FIFO at trigger level |
| rx_tmo_lvl_i | input | 1 | Receive inactivity timeout pending |
| frame_err_evt_i | input | 1 | Framing error pulse |
| brk_evt_i | input | 1 | Break detected pulse |
| ovr_evt_i | input | 1 | Receive overrun pulse |
| clr_we_i | input | 1 | Write strobe: ones in wr_data_i clear sticky bits |
| set_we_i | input | 1 | Write strobe: bit 6 of wr_data_i sets force-transmit |
| wr_data_i | input | 7 | Write data, same bit layout as status_o |
| tx_ie_i | input | 1 | Transmit group interrupt enable |
| rx_ie_i | input | 1 | Receive group interrupt enable |
| err_ie_i | input | 1 | Error group interrupt enable |
| status_o | output | 7 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker tests on every cycle that events set their sticky bits, that an event wins over a clear in the same cycle, and that an unwritten sticky bit holds its value. It also tests that a clearing write without an event empties the TX request bit, that the receive bits track their levels, and that irq_o stays low while all enables are off. Only the bench scenarios show the group routing of the interrupt line. These include an overrun that raises nothing under the receive and transmit enables, the rule that a set write reaches only bit 6, the clash between set and clear on bit 6, and recovery from a mid-run reset.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned ST_W  = 7;
  localparam int unsigned N_GRP = 3;
  localparam int unsigned GRP_TX  = 0;
  localparam int unsigned GRP_RX  = 1;
  localparam int unsigned GRP_ERR = 2;
  // sticky (write-one-to-clear) positions: 0,3,4,5,6
  localparam logic [ST_W-1:0] STICKY_MASK = 7'b1111001;
  // positions a set write may raise
  localparam logic [ST_W-1:0] SET_MASK    = 7'b1000000;
  localparam logic [ST_W-1:0] GRP_MASK [N_GRP] = '{
    7'b1000001,   // tx: request, force
    7'b0000110,   // rx: trigger, timeout
    7'b0111000    // err: frame, break, overrun
  };
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic [ST_W-1:0] lvl_i,
  output logic [ST_W-1:0] st_o
);
  logic [ST_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (set_i | (q & ~clr_i)) & STICKY_MASK;  // set beats clear
  end

  always_comb st_o = (q & STICKY_MASK) | (lvl_i & ~STICKY_MASK);
endmodule

// File: rtl/irq_combine.sv
module irq_combine
  import uart_irq_pkg::*;
(
  input  logic [ST_W-1:0]  st_i,
  input  logic [N_GRP-1:0] ie_i,
  output logic             irq_o
);
  logic [N_GRP-1:0] grp_hit;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_hit[g] = ie_i[g] & (|(st_i & GRP_MASK[g]));
  end

  assign irq_o = |grp_hit;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_req_evt_i,
  input  logic            rx_trig_lvl_i,
  input  logic            rx_tmo_lvl_i,
  input  logic            frame_err_evt_i,
  input  logic            brk_evt_i,
  input  logic            ovr_evt_i,
  input  logic            clr_we_i,
  input  logic            set_we_i,
  input  logic [ST_W-1:0] wr_data_i,
  input  logic            tx_ie_i,
  input  logic            rx_ie_i,
  input  logic            err_ie_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  logic [ST_W-1:0]  set_vec, clr_vec, lvl_vec, sw_set;
  logic [N_GRP-1:0] ie;

  assign sw_set  = set_we_i ? (wr_data_i & SET_MASK) : '0;
  assign set_vec = sw_set | {1'b0, ovr_evt_i, brk_evt_i, frame_err_evt_i,
                             2'b00, tx_req_evt_i};
  assign clr_vec = clr_we_i ? wr_data_i : '0;
  assign lvl_vec = {4'b0000, rx_tmo_lvl_i, rx_trig_lvl_i, 1'b0};

  assign ie[GRP_TX]  = tx_ie_i;
  assign ie[GRP_RX]  = rx_ie_i;
  assign ie[GRP_ERR] = err_ie_i;

  irq_status_reg u_st (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .lvl_i (lvl_vec),
    .st_o  (status_o)
  );

  irq_combine u_comb (
    .st_i (status_o),
    .ie_i (ie),
    .irq_o(irq_o)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_req_evt_i,
  input logic       rx_trig_lvl_i,
  input logic       rx_tmo_lvl_i,
  input logic       frame_err_evt_i,
  input logic       brk_evt_i,
  input logic       ovr_evt_i,
  input logic       clr_we_i,
  input logic       set_we_i,
  input logic [6:0] wr_data_i,
  input logic       tx_ie_i,
  input logic       rx_ie_i,
  input logic       err_ie_i,
  input logic [6:0] status_o,
  input logic       irq_o
);
  // R2
  frame_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_evt_i |=> status_o[3]);
  // R4
  brk_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_evt_i && clr_we_i && wr_data_i[4]) |=> status_o[4]);
  // R3
  tx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wr_data_i[0] && !tx_req_evt_i) |=> !status_o[0]);
  // R3
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_evt_i && !(clr_we_i && wr_data_i[5])) |=> $stable(status_o[5]));
  // R6
  force_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && wr_data_i[6]) |=> status_o[6]);
  // R5
  rx_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:1] == {rx_tmo_lvl_i, rx_trig_lvl_i});
  // R7
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_ie_i || rx_ie_i || err_ie_i) |-> !irq_o);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (.*);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_evt = 0, trig = 0, tmo = 0, frm = 0, brk = 0, ovr = 0;
  logic clr_we = 0, set_we = 0, tx_ie = 0, rx_ie = 0, err_ie = 0;
  logic [6:0] wdata = '0;
  logic [6:0] status;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tx_req_evt_i(tx_evt), .rx_trig_lvl_i(trig),
    .rx_tmo_lvl_i(tmo), .frame_err_evt_i(frm), .brk_evt_i(brk), .ovr_evt_i(ovr),
    .clr_we_i(clr_we), .set_we_i(set_we), .wr_data_i(wdata), .tx_ie_i(tx_ie),
    .rx_ie_i(rx_ie), .err_ie_i(err_ie), .status_o(status), .irq_o(irq)
  );

  // {ev{ovr,brk,frm,tmo,trig,tx}, clr, set, data, ie{err,rx,tx}, exp_st, exp_irq}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {6'b000001, 1'b0, 1'b0, 7'b0000000, 3'b000, 7'b0000001, 1'b0}, // R2 R8
    {6'b000000, 1'b0, 1'b0, 7'b0000000, 3'b001, 7'b0000001, 1'b1}, // R2 R7
    {6'b000000, 1'b1, 1'b0, 7'b1111000, 3'b001, 7'b0000001, 1'b1}, // R3 zero keeps
    {6'b000000, 1'b1, 1'b0, 7'b0000001, 3'b001, 7'b0000000, 1'b0}, // R3
    {6'b011000, 1'b0, 1'b0, 7'b0000000, 3'b000, 7'b0011000, 1'b0}, // R8
    {6'b000000, 1'b0, 1'b0, 7'b0000000, 3'b100, 7'b0011000, 1'b1}, // R7
    {6'b001000, 1'b1, 1'b0, 7'b0001000, 3'b100, 7'b0011000, 1'b1}, // R4
    {6'b000000, 1'b1, 1'b0, 7'b0011000, 3'b100, 7'b0000000, 1'b0}, // R3
    {6'b000010, 1'b0, 1'b0, 7'b0000000, 3'b010, 7'b0000010, 1'b1}, // R5
    {6'b000010, 1'b1, 1'b0, 7'b0000110, 3'b010, 7'b0000010, 1'b1}, // R5
    {6'b000100, 1'b0, 1'b0, 7'b0000000, 3'b000, 7'b0000100, 1'b0}, // R5
    {6'b000000, 1'b0, 1'b1, 7'b1111111, 3'b000, 7'b1000000, 1'b0}, // R6
    {6'b000000, 1'b0, 1'b0, 7'b0000000, 3'b001, 7'b1000000, 1'b1}, // R6 R7
    {6'b000000, 1'b1, 1'b1, 7'b1000000, 3'b001, 7'b1000000, 1'b1}, // R6
    {6'b000000, 1'b1, 1'b0, 7'b1000000, 3'b001, 7'b0000000, 1'b0}, // R3
    {6'b100000, 1'b0, 1'b0, 7'b0000000, 3'b011, 7'b0100000, 1'b0}, // R7
    {6'b000000, 1'b0, 1'b0, 7'b0000000, 3'b100, 7'b0100000, 1'b1}, // R7
    {6'b000000, 1'b1, 1'b0, 7'b0100000, 3'b100, 7'b0000000, 1'b0}  // R3
  };

  task automatic check(input string req, input logic [6:0] exp_st, input logic exp_irq);
    n_chk++;
    if (status !== exp_st || irq !== exp_irq) begin
      n_fail++;
      $display("FIL_%0s FAIL %s: status=%b irq=%b expected status=%b irq=%b",
               "", req, status, irq, exp_st, exp_irq);
    end
  endtask

  task automatic apply(input logic [25:0] v);
    @(negedge clk);
    {ovr, brk, frm, tmo, trig, tx_evt} = v[25:20];
    clr_we = v[19]; set_we = v[18]; wdata = v[17:11];
    {err_ie, rx_ie, tx_ie} = v[10:8];
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #5;
    check("R1 in reset", 7'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", 7'b0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("vector %0d (R2-R8 table)", i), VEC[i][7:1], VEC[i][0]);
    end
    // R1: mid-run reset wipes sticky bits
    apply({6'b111001, 1'b0, 1'b1, 7'b1000000, 3'b111, 7'b0, 1'b0});
    @(negedge clk);
    {ovr, brk, frm, tmo, trig, tx_evt} = '0; set_we = 0;
    rst_n = 1'b0; #1;
    check("R1 mid-run reset", 7'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 stays clear", 7'b0, 1'b0);
    // R2: break pulse with only err enabled
    apply({6'b010000, 1'b0, 1'b0, 7'b0, 3'b100, 7'b0, 1'b0});
    check("R2 break latch", 7'b0010000, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule